// File: doc/BRIEF.md
# Configurable Interrupt Trigger Detector

This block turns a vector of raw interrupt lines into per-source pending flags. Each source is qualified by its own trigger mode: a level mode, or a falling, rising or double edge mode. A source that qualifies raises a one-cycle issue strobe for the downstream arbiter. A level source whose line drops while it is pending raises a withdraw indication, so the arbiter can take back a request it may have forwarded. Arbitration and priority are outside this block.

Sources below a configurable base index have modes fixed at reset. Sources from the base index upward are external pins. Each pin has a byte-wide control register, and its trigger mode sits in bits 3:2 of that register. Software clears a pending flag by writing a 0 through a plain strobe, a source index and a data bit. All inputs are synchronous to `clk`. The clear and configuration ports are plain control pins with no back-pressure: every strobe is accepted in the cycle it is presented.

Top module: `trig_detect`

## Requirements
- R1: The mode encoding is 0 = level, 1 = falling edge, 2 = rising edge, 3 = both edges. Each source registers its line every cycle as its previous level, which resets to 0.
- R2: In rising mode, `issue[i]` is high in the cycle where the line is 1 and the previous level is 0. `pending[i]` is 1 after the next clock edge.
- R3: In falling mode, `issue[i]` is high when the previous level is 1 and the line is 0. A rising transition does not issue.
- R4: In both-edge mode, any difference between the line and the previous level issues and sets pending.
- R5: In level mode, `issue[i]` follows the line while it is high and sets pending. When the line is 0, pending clears at the next edge. `withdraw[i]` is high in the cycle where a level source is pending and its line is 0.
- R6: A clear strobe (`clr_we`=1, `clr_wdata`=0) clears `pending[clr_idx]` at the next edge for an edge-mode source. A detection in the same cycle takes precedence and leaves the flag set.
- R7: The following clear writes have no effect on any pending flag: a write of 1, a write to a level-mode source, and a write whose index is at or above the source count. A pending flag never sets without an issue.
- R8: After reset, all pending flags are 0. Sources marked in `LEVEL_MASK` start in level mode and all other sources start in rising mode.
- R9: Pin register k (`cfg_idx`=k) holds the mode of source `PIN_BASE`+k in bits 3:2. A write with `cfg_we` takes only those bits. `cfg_rdata` shows the addressed register with every other bit 0.
- R10: An edge-mode pending flag stays set until it is cleared, whatever the line does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_line | input | NUM_SRC | Raw interrupt lines, synchronous to clk |
| clr_we | input | 1 | Software pending-write strobe |
| clr_idx | input | $clog2(NUM_SRC) | Source addressed by the pending write |
| clr_wdata | input | 1 | Written value; only 0 can clear |
| cfg_we | input | 1 | Pin control register write strobe |
| cfg_idx | input | PIN_IDX_W | Pin control register index (read and write) |
| cfg_wdata | input | 8 | Pin control register write data; mode in bits 3:2 |
| cfg_rdata | output | 8 | Addressed pin control register |
| pending | output | NUM_SRC | Per-source pending flags |
| issue | output | NUM_SRC | Per-source request strobe to the arbiter |
| withdraw | output | NUM_SRC | Level source pending with its line low |

## Verification
A stale or wrongly reset previous-level register shows up on `issue` in the same cycle as the line change. It appears as a spurious or missing strobe on the very first transition after reset. A wrong mode register or a bad clear decode shows up on `pending` one edge after the stimulus. The bench samples both of these points: the strobe in the stimulus cycle and the flag after the next edge. Mode bits that end up in the wrong field position are exposed at once by reading back `cfg_rdata`.

// File: rtl/trig_pkg.sv
package trig_pkg;

  typedef enum logic [1:0] {
    TRG_LVL  = 2'd0,
    TRG_FALL = 2'd1,
    TRG_RISE = 2'd2,
    TRG_ANY  = 2'd3
  } trig_mode_e;

  localparam int MODE_LSB = 2;
  localparam int MODE_MSB = 3;

  // qualifies one sample against the previous one under a mode
  function automatic logic trig_hit(input logic [1:0] mode,
                                    input logic       prev,
                                    input logic       cur);
    logic h;
    case (mode)
      TRG_LVL:  h = cur;
      TRG_FALL: h = prev & ~cur;
      TRG_RISE: h = ~prev & cur;
      default:  h = prev ^ cur;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/trig_mode_bank.sv
module trig_mode_bank
  import trig_pkg::*;
#(
  parameter int                    NUM_SRC    = 80,
  parameter int                    PIN_BASE   = 64,
  parameter logic [NUM_SRC-1:0]    LEVEL_MASK = '0,
  localparam int                   NUM_PIN    = NUM_SRC - PIN_BASE,
  localparam int                   PIN_IDX_W  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [PIN_IDX_W-1:0]       cfg_idx,
  input  logic [7:0]                 cfg_wdata,
  output logic [7:0]                 cfg_rdata,
  output logic [NUM_SRC-1:0][1:0]    mode_o
);

  logic [NUM_PIN-1:0][1:0] pin_mode_q;

  // fixed-mode internal sources
  for (genvar i = 0; i < PIN_BASE; i++) begin : g_fixed
    assign mode_o[i] = LEVEL_MASK[i] ? TRG_LVL : TRG_RISE;
  end

  // writable pin sources
  for (genvar k = 0; k < NUM_PIN; k++) begin : g_pin
    localparam logic [1:0] RST_MODE = LEVEL_MASK[PIN_BASE+k] ? TRG_LVL : TRG_RISE;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pin_mode_q[k] <= RST_MODE;
      end else if (cfg_we && (int'(cfg_idx) == k)) begin
        pin_mode_q[k] <= cfg_wdata[MODE_MSB:MODE_LSB];
      end
    end
    assign mode_o[PIN_BASE+k] = pin_mode_q[k];
  end

  always_comb begin
    cfg_rdata = '0;
    if (int'(cfg_idx) < NUM_PIN) begin
      cfg_rdata[MODE_MSB:MODE_LSB] = pin_mode_q[cfg_idx];
    end
  end

endmodule

// File: rtl/trig_clr_decode.sv
module trig_clr_decode #(
  parameter int  NUM_SRC = 80,
  localparam int IDX_W   = $clog2(NUM_SRC)
) (
  input  logic               clr_we,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               clr_wdata,
  output logic [NUM_SRC-1:0] clr_sel
);

  // only a write of zero is a clear request; indices past the end match nothing
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
    assign clr_sel[i] = clr_we & ~clr_wdata & (clr_idx == IDX_W'(i));
  end

endmodule

// File: rtl/trig_src_cell.sv
module trig_src_cell
  import trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line,
  input  logic [1:0] mode,
  input  logic       clr_req,
  output logic       issue,
  output logic       pending,
  output logic       withdraw
);

  logic prev_q;
  logic pend_q;
  logic is_lvl;

  assign is_lvl   = (mode == TRG_LVL);
  assign issue    = trig_hit(mode, prev_q, line);
  assign withdraw = is_lvl & ~line & pend_q;
  assign pending  = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line;
      if (issue) begin
        pend_q <= 1'b1;
      end else if (is_lvl) begin
        pend_q <= 1'b0;
      end else if (clr_req) begin
        pend_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/trig_detect.sv
module trig_detect
  import trig_pkg::*;
#(
  parameter int                 NUM_SRC    = 80,
  parameter int                 PIN_BASE   = 64,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = (NUM_SRC'(1) << 3) | (NUM_SRC'(1) << 66),
  localparam int                IDX_W      = $clog2(NUM_SRC),
  localparam int                NUM_PIN    = NUM_SRC - PIN_BASE,
  localparam int                PIN_IDX_W  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SRC-1:0]   irq_line,
  input  logic                 clr_we,
  input  logic [IDX_W-1:0]     clr_idx,
  input  logic                 clr_wdata,
  input  logic                 cfg_we,
  input  logic [PIN_IDX_W-1:0] cfg_idx,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic [NUM_SRC-1:0]   pending,
  output logic [NUM_SRC-1:0]   issue,
  output logic [NUM_SRC-1:0]   withdraw
);

  logic [NUM_SRC-1:0][1:0] mode_w;
  logic [NUM_SRC-1:0]      clr_sel;

  trig_mode_bank #(
    .NUM_SRC    (NUM_SRC),
    .PIN_BASE   (PIN_BASE),
    .LEVEL_MASK (LEVEL_MASK)
  ) u_modes (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .mode_o    (mode_w)
  );

  trig_clr_decode #(.NUM_SRC(NUM_SRC)) u_clr (
    .clr_we    (clr_we),
    .clr_idx   (clr_idx),
    .clr_wdata (clr_wdata),
    .clr_sel   (clr_sel)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    trig_src_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .line     (irq_line[i]),
      .mode     (mode_w[i]),
      .clr_req  (clr_sel[i]),
      .issue    (issue[i]),
      .pending  (pending[i]),
      .withdraw (withdraw[i])
    );
  end

endmodule

// File: rtl/trig_detect_chk.sv
module trig_detect_chk #(
  parameter int NUM_SRC = 80
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_SRC-1:0]      irq_line,
  input logic [NUM_SRC-1:0][1:0] mode_w,
  input logic [7:0]              cfg_rdata,
  input logic [NUM_SRC-1:0]      pending,
  input logic [NUM_SRC-1:0]      issue,
  input logic [NUM_SRC-1:0]      withdraw
);

  logic [NUM_SRC-1:0] lvl_low;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      lvl_low[i] = (mode_w[i] == 2'd0) & ~irq_line[i];
    end
  end

  AST_ISSUE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|issue) |=> ((pending & $past(issue)) == $past(issue))); // R2

  AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (|lvl_low) |=> ((pending & $past(lvl_low)) == '0)); // R5

  AST_WITHDRAW_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (|withdraw) |=> ((pending & $past(withdraw)) == '0)); // R5

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((pending & ~$past(pending) & ~$past(issue)) == '0)); // R7

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pending == '0)); // R8

  always_comb begin
    if (rst_n) begin
      AST_RDATA_FIELD: assert (cfg_rdata[7:4] == 4'd0 && cfg_rdata[1:0] == 2'd0); // R9
    end
  end

endmodule

bind trig_detect trig_detect_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_line  (irq_line),
  .mode_w    (mode_w),
  .cfg_rdata (cfg_rdata),
  .pending   (pending),
  .issue     (issue),
  .withdraw  (withdraw)
);

// File: tb/sim_trig_detect.sv
`timescale 1ns/1ps
module sim_trig_detect;

  localparam int NUM_SRC = 80;
  localparam int IDX_W   = 7;
  localparam int PIDX_W  = 4;

  logic               clk = 1'b0;
  logic               rst_n;
  logic [NUM_SRC-1:0] irq_line;
  logic               clr_we;
  logic [IDX_W-1:0]   clr_idx;
  logic               clr_wdata;
  logic               cfg_we;
  logic [PIDX_W-1:0]  cfg_idx;
  logic [7:0]         cfg_wdata;
  logic [7:0]         cfg_rdata;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] issue;
  logic [NUM_SRC-1:0] withdraw;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  trig_detect u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_line  (irq_line),
    .clr_we    (clr_we),
    .clr_idx   (clr_idx),
    .clr_wdata (clr_wdata),
    .cfg_we    (cfg_we),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .pending   (pending),
    .issue     (issue),
    .withdraw  (withdraw)
  );

  // scoreboard: kind 0 pending, 1 issue, 2 withdraw, 3 cfg_rdata
  typedef struct {
    int         kind;
    int         idx;
    logic [7:0] exp;
    string      tag;
  } exp_t;

  exp_t sbq[$];

  function automatic void want(int kind, int idx, logic [7:0] v, string tag);
    exp_t e;
    e.kind = kind; e.idx = idx; e.exp = v; e.tag = tag;
    sbq.push_back(e);
  endfunction

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      exp_t e;
      logic [7:0] act;
      e = sbq.pop_front();
      case (e.kind)
        0:       act = {7'd0, pending[e.idx]};
        1:       act = {7'd0, issue[e.idx]};
        2:       act = {7'd0, withdraw[e.idx]};
        default: act = cfg_rdata;
      endcase
      n_run++;
      if (act !== e.exp) begin
        n_fail++;
        $display("[TB] FAIL %s kind=%0d src=%0d actual=%0h expected=%0h",
                 e.tag, e.kind, e.idx, act, e.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic clr(int idx, logic wd);
    clr_we = 1'b1; clr_idx = IDX_W'(idx); clr_wdata = wd;
    tick();
    clr_we = 1'b0;
  endtask

  task automatic cfg(int k, logic [7:0] wd);
    cfg_we = 1'b1; cfg_idx = PIDX_W'(k); cfg_wdata = wd;
    tick();
    cfg_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("[TB] FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_line = '0; clr_we = 1'b0; clr_idx = '0; clr_wdata = 1'b0;
    cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R8 / R1: reset state and default modes
    want(0, 5, 0, "R8"); want(0, 3, 0, "R8");
    want(3, 0, 8'h08, "R8");
    tick();
    cfg_idx = 4'd2;
    want(3, 2, 8'h00, "R8");
    tick();

    // R2 rising on internal source 5, previous level reset to 0 (R1)
    irq_line[5] = 1'b1;
    want(1, 5, 1, "R2");
    tick();
    want(0, 5, 1, "R2"); want(1, 5, 0, "R1");
    tick();
    irq_line[5] = 1'b0;
    want(1, 5, 0, "R2");
    tick();
    want(0, 5, 1, "R10");

    // R7: write of 1 and out-of-range index
    clr(5, 1'b1);
    want(0, 5, 1, "R7");
    clr(100, 1'b0);
    want(0, 5, 1, "R7");

    // R6: clear and detection precedence
    clr(5, 1'b0);
    want(0, 5, 0, "R6");
    irq_line[5] = 1'b1;
    want(1, 5, 1, "R6");
    clr(5, 1'b0);
    want(0, 5, 1, "R6");
    irq_line[5] = 1'b0;
    clr(5, 1'b0);
    want(0, 5, 0, "R6");

    // R5: level source 3
    irq_line[3] = 1'b1;
    want(1, 3, 1, "R5"); want(2, 3, 0, "R5");
    tick();
    want(0, 3, 1, "R5"); want(1, 3, 1, "R5");
    clr(3, 1'b0);
    want(0, 3, 1, "R7");
    irq_line[3] = 1'b0;
    want(2, 3, 1, "R5"); want(1, 3, 0, "R5");
    tick();
    want(0, 3, 0, "R5"); want(2, 3, 0, "R5");

    // R9 / R3: pin 0 (source 64) to falling, extra bits dropped
    cfg(0, 8'hF7);
    want(3, 0, 8'h04, "R9");
    irq_line[64] = 1'b1;
    want(1, 64, 0, "R3");
    tick();
    want(0, 64, 0, "R3");
    irq_line[64] = 1'b0;
    want(1, 64, 1, "R3");
    tick();
    want(0, 64, 1, "R3");

    // R4: pin 1 (source 65) to both edges
    cfg(1, 8'h0C);
    want(3, 1, 8'h0C, "R1");
    irq_line[65] = 1'b1;
    want(1, 65, 1, "R4");
    tick();
    want(0, 65, 1, "R4");
    clr(65, 1'b0);
    want(0, 65, 0, "R6");
    irq_line[65] = 1'b0;
    want(1, 65, 1, "R4");
    tick();
    want(0, 65, 1, "R4");

    // R8 / R9: pin 2 (source 66) starts level, then switched to rising
    irq_line[66] = 1'b1;
    want(1, 66, 1, "R8");
    tick();
    want(0, 66, 1, "R8");
    cfg(2, 8'h08);
    want(1, 66, 0, "R9"); want(0, 66, 1, "R9");
    clr(66, 1'b0);
    want(0, 66, 0, "R6");
    tick();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule